// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single line. A one-character holding register sits in front of a frame shift register. Software-side logic can therefore queue the next character while the current one is still going out, and a queued character follows the previous stop bit with no idle gap. A character has 8, 9 or 10 data bits and may carry an even or odd parity bit. The bit rate comes from a programmable divider multiplied by an oversampling ratio.

Two status flags report the state of the two stages. The holding-empty flag shows that the holding register can accept a character. The complete flag shows that both stages are empty. Each flag drives an interrupt request through its own enable. A break request replaces the next frame with an all-low character, followed by one bit time of high line.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset the line is high, the holding-empty and complete flags are 1, and each interrupt output equals its enable input.
- R2: A data frame is sent least significant bit first. It has a low start bit, then the data bits, then the optional parity bit, then one high stop bit. There are 8 data bits by default, 9 when `fmt9_i` is 1, and 10 when `fmt10_i` is 1 (`fmt10_i` wins). The line idles high.
- R3: With `par_en_i`=1 a parity bit follows the last data bit. When `par_odd_i`=0 it makes the count of ones even; when `par_odd_i`=1 it makes the count odd. With `par_en_i`=0 no parity bit is sent.
- R4: Every bit lasts (osr+1)×sbr clock cycles. An `osr_i` value below 3 acts as 3. While `sbr_i` is 0 the frame does not advance.
- R5: A write is accepted only when the holding register is empty. The holding-empty flag is 0 while a character waits there, and a write made while it is full is dropped.
- R6: The complete flag is 1 only when both the holding register and the shift register are empty. It is 0 during every transmitted bit, including the stop bit.
- R7: With `tx_en_i`=0 no frame starts and the line stays high. A character written while disabled is kept and is sent once the transmitter is enabled.
- R8: A break request starts, when the shifter is free, a low period lasting the current frame length (start bit through stop-bit position), followed by one high bit time. A break takes precedence over a waiting character.
- R9: A character waiting in the holding register starts its start bit on the same cycle the previous stop bit ends.
- R10: `irq_hold_o` equals holding-empty AND `tie_i`, and `irq_done_o` equals complete AND `tcie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmitter enable |
| wr_valid_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 10 | Character to send (low bits used for 8/9-bit formats) |
| fmt9_i | input | 1 | Select 9 data bits |
| fmt10_i | input | 1 | Select 10 data bits (overrides fmt9_i) |
| par_en_i | input | 1 | Append a parity bit |
| par_odd_i | input | 1 | 0 even, 1 odd parity |
| brk_i | input | 1 | Break request |
| sbr_i | input | 13 | Baud divider; 0 halts bit timing |
| osr_i | input | 5 | Oversampling ratio, 3 to 31 |
| tie_i | input | 1 | Holding-empty interrupt enable |
| tcie_i | input | 1 | Complete interrupt enable |
| tx_o | output | 1 | Serial line |
| hold_empty_o | output | 1 | Holding register can take a character |
| tx_done_o | output | 1 | Both stages empty |
| irq_hold_o | output | 1 | Holding-empty interrupt request |
| irq_done_o | output | 1 | Complete interrupt request |

## Verification
The hardest state to reach is the one where both stages are full: one character is shifting while a second waits in the holding register. Only there is a third write dropped and the seamless hand-over tested. The bench reaches it by starting a concurrent line monitor first, then issuing three back-to-back writes. It samples two frames as one continuous bit stream, so any gap between them shows up as a misaligned bit. Break precedence is reached by parking a character while the transmitter is disabled, raising the break request, and only then enabling.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 10;
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  // start(0) + data LSB first + optional parity + stop(1); unused upper bits stay 1
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [DATA_W-1:0] d,
    input logic [LEN_W-1:0]  nd,
    input logic              pe,
    input logic              odd
  );
    logic [FRAME_W-1:0] f;
    logic [DATA_W-1:0]  m;
    logic [DATA_W-1:0]  dm;
    logic [LEN_W-1:0]   pidx;
    m    = ~({DATA_W{1'b1}} << nd);
    dm   = d & m;
    f    = '1;
    f[0] = 1'b0;
    f[DATA_W:1] = dm | ~m;
    pidx = nd + LEN_W'(1);
    if (pe) f[pidx] = odd ^ (^dm);
    return f;
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int SBR_W   = 13,
  parameter int OSR_W   = 5,
  parameter int OSR_MIN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SBR_W-1:0] sbr_i,
  input  logic [OSR_W-1:0] osr_i,
  output logic             tick_o
);
  logic [SBR_W-1:0] sbr_cnt;
  logic [OSR_W-1:0] osr_cnt;
  logic [OSR_W-1:0] osr_eff;
  logic             sbr_last;
  logic             sbr_zero;

  assign osr_eff  = (osr_i < OSR_W'(OSR_MIN)) ? OSR_W'(OSR_MIN) : osr_i;
  assign sbr_zero = (sbr_i == '0);
  assign sbr_last = (sbr_cnt == (sbr_i - SBR_W'(1)));
  assign tick_o   = run_i && !sbr_zero && sbr_last && (osr_cnt == osr_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbr_cnt <= '0;
      osr_cnt <= '0;
    end else if (!run_i) begin
      sbr_cnt <= '0;
      osr_cnt <= '0;
    end else if (!sbr_zero) begin
      if (sbr_last) begin
        sbr_cnt <= '0;
        osr_cnt <= (osr_cnt == osr_eff) ? '0 : osr_cnt + OSR_W'(1);
      end else begin
        sbr_cnt <= sbr_cnt + SBR_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_valid_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (take_i) begin
      full_o <= 1'b0;
    end else if (wr_valid_i && !full_o) begin
      full_o <= 1'b1;
      data_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int W     = 14,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     frame_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             last_o,
  output logic             line_o
);
  logic [W-1:0]     sh;
  logic [CNT_W-1:0] cnt;

  assign last_o = busy_o && tick_i && (cnt == CNT_W'(1));
  assign line_o = !busy_o || sh[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh     <= '1;
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (load_i) begin
      sh     <= frame_i;
      cnt    <= len_i;
      busy_o <= 1'b1;
    end else if (busy_o && tick_i) begin
      sh  <= {1'b1, sh[W-1:1]};
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int SBR_W   = 13,
  parameter int OSR_W   = 5,
  parameter int OSR_MIN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fmt9_i,
  input  logic              fmt10_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              brk_i,
  input  logic [SBR_W-1:0]  sbr_i,
  input  logic [OSR_W-1:0]  osr_i,
  input  logic              tie_i,
  input  logic              tcie_i,
  output logic              tx_o,
  output logic              hold_empty_o,
  output logic              tx_done_o,
  output logic              irq_hold_o,
  output logic              irq_done_o
);
  logic               hold_full;
  logic [DATA_W-1:0]  hold_data;
  logic               busy, last_bit, tick, free;
  logic               start_data, start_brk, load;
  logic [LEN_W-1:0]   ndata, frame_len, load_len;
  logic [FRAME_W-1:0] data_frame, brk_frame, load_frame;

  always_comb begin
    if (fmt10_i)     ndata = LEN_W'(DATA_W);
    else if (fmt9_i) ndata = LEN_W'(DATA_W - 1);
    else             ndata = LEN_W'(DATA_W - 2);
  end

  assign frame_len  = ndata + LEN_W'(2) + LEN_W'(par_en_i);
  assign data_frame = build_frame(hold_data, ndata, par_en_i, par_odd_i);
  assign brk_frame  = FRAME_W'(1) << frame_len;  // low for frame_len bits, then one high bit

  // shifter free now or on its final bit edge: keeps queued frames gapless
  assign free       = !busy || last_bit;
  assign start_brk  = tx_en_i && brk_i && free;
  assign start_data = tx_en_i && !brk_i && hold_full && free;
  assign load       = start_brk || start_data;
  assign load_frame = start_brk ? brk_frame : data_frame;
  assign load_len   = start_brk ? frame_len + LEN_W'(1) : frame_len;

  uart_tx_hold #(.W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_valid_i(wr_valid_i),
    .wr_data_i (wr_data_i),
    .take_i    (start_data),
    .full_o    (hold_full),
    .data_o    (hold_data)
  );

  uart_tx_baud #(.SBR_W(SBR_W), .OSR_W(OSR_W), .OSR_MIN(OSR_MIN)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .sbr_i (sbr_i),
    .osr_i (osr_i),
    .tick_o(tick)
  );

  uart_tx_shift #(.W(FRAME_W), .CNT_W(LEN_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .frame_i(load_frame),
    .len_i  (load_len),
    .tick_i (tick),
    .busy_o (busy),
    .last_o (last_bit),
    .line_o (tx_o)
  );

  assign hold_empty_o = !hold_full;
  assign tx_done_o    = !hold_full && !busy;
  assign irq_hold_o   = hold_empty_o && tie_i;
  assign irq_done_o   = tx_done_o && tcie_i;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk #(
  parameter int SBR_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_en_i,
  input logic             wr_valid_i,
  input logic [SBR_W-1:0] sbr_i,
  input logic             tx_o,
  input logic             hold_empty_o,
  input logic             tx_done_o
);
  // R2
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> tx_o);

  // R6
  done_needs_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> hold_empty_o);

  // R5
  hold_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_empty_o) |-> $past(wr_valid_i));

  // R7
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && tx_done_o) |=> tx_o);

  // R4
  sbr_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbr_i == '0 && !tx_o) |=> !tx_o);
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk #(.SBR_W(SBR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_i     (tx_en_i),
  .wr_valid_i  (wr_valid_i),
  .sbr_i       (sbr_i),
  .tx_o        (tx_o),
  .hold_empty_o(hold_empty_o),
  .tx_done_o   (tx_done_o)
);

// File: tb/uart_tx_dbuf_tb_top.sv
module uart_tx_dbuf_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_en_i = 1'b0, wr_valid_i = 1'b0;
  logic [9:0]  wr_data_i = '0;
  logic        fmt9_i = 1'b0, fmt10_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0, brk_i = 1'b0;
  logic [12:0] sbr_i = 13'd2;
  logic [4:0]  osr_i = 5'd3;
  logic        tie_i = 1'b1, tcie_i = 1'b1;
  logic        tx_o, hold_empty_o, tx_done_o, irq_hold_o, irq_done_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] cap_bits;
  bit cap_done;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  uart_tx_dbuf dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nd_of(bit f9, bit f10);
    return f10 ? 10 : (f9 ? 9 : 8);
  endfunction

  function automatic int exp_len(bit f9, bit f10, bit pe);
    return nd_of(f9, f10) + 2 + int'(pe);
  endfunction

  function automatic logic [31:0] exp_frame(logic [9:0] d, bit f9, bit f10, bit pe, bit po);
    logic [31:0] r = '0;
    int k = 1;
    bit p = po;
    for (int i = 0; i < nd_of(f9, f10); i++) begin
      r[k] = d[i]; p ^= d[i]; k++;
    end
    if (pe) begin r[k] = p; k++; end
    r[k] = 1'b1;
    return r;
  endfunction

  function automatic int period();
    int o = (osr_i < 3) ? 3 : int'(osr_i);
    return (o + 1) * int'(sbr_i);
  endfunction

  task automatic write(input logic [9:0] d);
    @(negedge clk_i); wr_valid_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_valid_i = 1'b0;
  endtask

  task automatic wait_low();
    int t = 0;
    while (tx_o !== 1'b0 && t < 20000) begin @(negedge clk_i); t++; end
  endtask

  task automatic capture(input int nbits, input int p, output logic [31:0] got);
    got = '0;
    wait_low();
    repeat (p / 2) @(negedge clk_i);
    got[0] = tx_o;
    for (int k = 1; k < nbits; k++) begin
      repeat (p) @(negedge clk_i);
      got[k] = tx_o;
    end
  endtask

  task automatic wait_done();
    int t = 0;
    while (!tx_done_o && t < 20000) begin @(negedge clk_i); t++; end
  endtask

  task automatic count_low(output int n);
    n = 0;
    wait_low();
    while (tx_o === 1'b0 && n < 20000) begin
      brk_i = 1'b0;
      n++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] e, m;
    int n, p, len;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(tx_o === 1'b1, "R1 line", tx_o, 1);
    chk(hold_empty_o === 1'b1 && tx_done_o === 1'b1, "R1 flags", {hold_empty_o, tx_done_o}, 3);
    chk(irq_hold_o === 1'b1 && irq_done_o === 1'b1, "R1 R10 irq", {irq_hold_o, irq_done_o}, 3);

    // R7 disabled: character parked, line quiet
    write(10'h05A);
    chk(hold_empty_o === 1'b0 && tx_done_o === 1'b0, "R7 R5 parked", {hold_empty_o, tx_done_o}, 0);
    chk(irq_hold_o === 1'b0, "R10 irq_hold off", irq_hold_o, 0);
    n = 0;
    repeat (60) begin @(negedge clk_i); if (tx_o !== 1'b1) n++; end
    chk(n == 0, "R7 no frame while disabled", n, 0);
    tx_en_i = 1'b1;
    capture(10, 8, cap_bits);
    e = exp_frame(10'h05A, 0, 0, 0, 0);
    chk(cap_bits == e, "R2 R7 frame after enable", cap_bits, e);
    wait_done();
    chk(tx_done_o === 1'b1 && irq_done_o === 1'b1, "R6 R10 done", {tx_done_o, irq_done_o}, 3);

    // R4 bit period
    sbr_i = 13'd3; osr_i = 5'd4;
    write(10'h001);
    count_low(n);
    chk(n == 15, "R4 period 5x3", n, 15);
    wait_done();
    sbr_i = 13'd2; osr_i = 5'd1;
    write(10'h001);
    count_low(n);
    chk(n == 8, "R4 osr clamp", n, 8);
    wait_done();

    // R4 divider zero halts
    sbr_i = 13'd0; osr_i = 5'd3;
    write(10'h001);
    wait_low();
    repeat (100) @(negedge clk_i);
    chk(tx_o === 1'b0 && tx_done_o === 1'b0, "R4 sbr zero stall", {tx_o, tx_done_o}, 0);
    sbr_i = 13'd2;
    wait_done();
    chk(tx_done_o === 1'b1, "R4 resume", tx_done_o, 1);

    // R9 R5: both stages full, third write dropped, gapless hand-over
    cap_done = 0;
    fork
      begin capture(20, 8, cap_bits); cap_done = 1; end
    join_none
    write(10'h0A5);
    write(10'h03C);
    chk(hold_empty_o === 1'b0 && tx_done_o === 1'b0, "R5 both full", {hold_empty_o, tx_done_o}, 0);
    write(10'h0FF);
    while (!cap_done) @(negedge clk_i);
    e = (exp_frame(10'h03C, 0, 0, 0, 0) << 10) | exp_frame(10'h0A5, 0, 0, 0, 0);
    chk(cap_bits == e, "R9 back-to-back", cap_bits, e);
    n = 0;
    repeat (260) begin @(negedge clk_i); if (tx_o !== 1'b1) n++; end
    chk(n == 0, "R5 dropped write", n, 0);
    chk(tx_done_o === 1'b1, "R6 done after pair", tx_done_o, 1);

    // R8 break precedence over parked data
    tx_en_i = 1'b0;
    write(10'h033);
    brk_i = 1'b1;
    @(negedge clk_i); tx_en_i = 1'b1;
    count_low(n);
    chk(n == 80, "R8 break low 8N1", n, 80);
    n = 0;
    while (tx_o === 1'b1 && n < 1000) begin n++; @(negedge clk_i); end
    chk(n == 8, "R8 break high bit", n, 8);
    capture(10, 8, cap_bits);
    e = exp_frame(10'h033, 0, 0, 0, 0);
    chk(cap_bits == e, "R8 data after break", cap_bits, e);
    wait_done();

    // R8 break with 10-bit parity format
    fmt10_i = 1'b1; par_en_i = 1'b1;
    brk_i = 1'b1;
    count_low(n);
    chk(n == 13 * 8, "R8 break low 10E1", n, 104);
    wait_done();
    chk(tx_done_o === 1'b1, "R8 done after break", tx_done_o, 1);

    // R2 R3 R10 random formats
    for (int it = 0; it < 24; it++) begin
      logic [9:0] d;
      bit f9, f10, pe, po;
      d = 10'($urandom);
      f9 = 1'($urandom); f10 = 1'($urandom); pe = 1'($urandom); po = 1'($urandom);
      if (it == 0) begin f9 = 1; f10 = 0; pe = 1; po = 0; end
      if (it == 1) begin f9 = 0; f10 = 0; pe = 1; po = 1; end
      fmt9_i = f9; fmt10_i = f10; par_en_i = pe; par_odd_i = po;
      sbr_i = 13'(1 + $urandom_range(0, 2));
      osr_i = 5'(3 + $urandom_range(0, 3));
      tie_i = 1'($urandom); tcie_i = 1'($urandom);
      p = period();
      len = exp_len(f9, f10, pe);
      write(d);
      capture(len, p, cap_bits);
      m = (32'h1 << len) - 1;
      e = exp_frame(d, f9, f10, pe, po) & m;
      chk((cap_bits & m) == e, "R2 R3 random frame", cap_bits, e);
      chk(tx_done_o === 1'b0 && hold_empty_o === 1'b1, "R6 stop bit busy", {tx_done_o, hold_empty_o}, 1);
      wait_done();
      chk(irq_hold_o === tie_i && irq_done_o === tcie_i, "R10 irq gating",
          {irq_hold_o, irq_done_o}, {tie_i, tcie_i});
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule